// File: doc/BRIEF.md
# Bus-Attached Accumulator Unit

This unit is one processing element on a shared value bus. The bus is formed by OR-ing together the outputs of every unit attached to it. A central sequencer steers the unit with raw control strobes and no decoder: `ctl_load`, `ctl_clear`, `ctl_neg` and `ctl_out`.

A clear-and-load command (`ctl_load` and `ctl_clear` both high) throws away the old sum and takes the operand from the bus. A plain load command (`ctl_load` high, `ctl_clear` low) folds the next bus operand into the running sum. With `ctl_neg` low it adds the operand; with `ctl_neg` high it subtracts it in two's complement. Either load command captures the operand in the tick in which the command is issued.

An out command makes the unit place its result on the bus during the following tick only. In every other tick the unit drives zero, so it never disturbs the other sources on the merged bus. The attribute lines are always driven to zero.

Top module: `acc_unit`

## Requirements
- R1: While `rst_n` is low, and after reset, `bus_out` is zero and the accumulator holds zero. An out command issued before any load therefore presents 0.
- R2: A tick with `ctl_load`=1, `ctl_clear`=1, `ctl_neg`=0 sets the accumulator to `bus_in` of that tick. The prior sum is discarded.
- R3: A tick with `ctl_load`=1, `ctl_clear`=0, `ctl_neg`=0 adds `bus_in` of that tick to the accumulator.
- R4: With `ctl_neg`=1, a load subtracts `bus_in` from the accumulator, and a clear-and-load stores the two's-complement negation of `bus_in`.
- R5: All arithmetic wraps modulo 2^DATA_W. For example, 0xFFFF + 1 gives 0 for DATA_W=16.
- R6: When `ctl_out`=1 in tick t, `bus_out` equals the accumulator value held at the start of tick t throughout tick t+1. A load in tick t is therefore not yet included.
- R7: In every tick not preceded by an out command, `bus_out` is zero. `attr_out` is zero at all times.
- R8: When `ctl_load`=0, the accumulator is unchanged whatever `ctl_clear`, `ctl_neg` and `bus_in` are.
- R9: An eight-tick counter program produces 1, 2, 3, 4 on the bus in four successive program cycles. In each cycle, tick 1 does a clear-and-load of the previous output, tick 3 loads the constant 1, and tick 5 issues out. The previous output is 0 in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clear | input | 1 | With ctl_load, start a new sum from the operand |
| ctl_load | input | 1 | Capture the bus operand this tick |
| ctl_neg | input | 1 | Subtract (negate) the operand instead of adding it |
| ctl_out | input | 1 | Source the result onto the bus next tick |
| bus_in | input | DATA_W | Merged value bus as seen by the unit |
| bus_out | output | DATA_W | Unit's contribution to the OR-merged bus |
| attr_out | output | ATTR_W | Attribute contribution, always zero |

## Verification
An operand captured in tick t changes the sum at the closing edge of tick t. Its effect is only visible through an out command, so every arithmetic result is due on `bus_out` one tick after the out command that follows the load. The bench drives each command at the falling edge and then samples `bus_out` at the next falling edge. That is the middle of tick t+1, where R6 says the result stands. A reference sum is kept in the bench and updated only after the old value has been captured for a pending out. Every tick is also checked for the zero-when-idle rule of R7, so a value held on the bus one tick too long is caught.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic neg;
    logic out;
  } acc_cmd_t;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/acc_operand.sv
module acc_operand #(
  parameter int DATA_W = 16
) (
  input  acc_pkg::acc_cmd_t cmd,
  input  logic [DATA_W-1:0] acc_q,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] sum_nx
);
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] base;

  always_comb begin
    operand = cmd.neg ? (~bus_in + {{(DATA_W-1){1'b0}}, 1'b1}) : bus_in;
    base    = cmd.clear ? '0 : acc_q;
    sum_nx  = base + operand;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] sum_nx,
  output logic [DATA_W-1:0] acc_q
);
  logic [DATA_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load) acc_d = sum_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc_q));
endmodule

// File: rtl/acc_drive.sv
module acc_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_cmd,
  input  logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] bus_out
);
  logic              drive_q, drive_d;
  logic [DATA_W-1:0] res_q, res_d;

  always_comb begin
    drive_d = out_cmd;
    res_d   = res_q;
    if (out_cmd) res_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      res_q   <= '0;
    end else begin
      drive_q <= drive_d;
      res_q   <= res_d;
    end
  end

  assign bus_out = drive_q ? res_q : '0;
endmodule

// File: rtl/acc_unit.sv
module acc_unit #(
  parameter int DATA_W = 16,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_clear,
  input  logic              ctl_load,
  input  logic              ctl_neg,
  input  logic              ctl_out,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [ATTR_W-1:0] attr_out
);
  import acc_pkg::*;

  logic              rst_sync_n;
  acc_cmd_t          cmd;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] sum_nx;
  logic              live_q;

  assign cmd = '{clear: ctl_clear, load: ctl_load, neg: ctl_neg, out: ctl_out};

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  acc_operand #(.DATA_W(DATA_W)) u_opnd (
    .cmd(cmd), .acc_q(acc_q), .bus_in(bus_in), .sum_nx(sum_nx));

  acc_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .load(cmd.load),
    .sum_nx(sum_nx), .acc_q(acc_q));

  acc_drive #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_sync_n), .out_cmd(cmd.out),
    .acc_q(acc_q), .bus_out(bus_out));

  assign attr_out = '0;

  // one cycle of history since reset release, used to guard $past checks
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  assert_clear_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_load && ctl_clear && !ctl_neg) |=> acc_q == $past(bus_in));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_load && !ctl_clear && !ctl_neg) |=> acc_q == $past(acc_q) + $past(bus_in));

  assert_sub_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_load && !ctl_clear && ctl_neg) |=> acc_q == $past(acc_q) - $past(bus_in));

  assert_out_next_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_q && $past(ctl_out)) |-> bus_out == $past(acc_q));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_q && !$past(ctl_out)) |-> bus_out == '0);

  always_comb begin
    if (!rst_n) assert_reset_zero_R1: assert (bus_out == '0);
  end
endmodule

// File: tb/acc_unit_tb.sv
module acc_unit_tb;
  localparam int W = 16;
  localparam int A = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ctl_clear, ctl_load, ctl_neg, ctl_out;
  logic [W-1:0] bus_in;
  logic [W-1:0] bus_out;
  logic [A-1:0] attr_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  acc_unit #(.DATA_W(W), .ATTR_W(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .ctl_load(ctl_load),
    .ctl_neg(ctl_neg), .ctl_out(ctl_out), .bus_in(bus_in),
    .bus_out(bus_out), .attr_out(attr_out));

  function automatic logic [W-1:0] ref_next(logic [W-1:0] acc, bit clr, bit ld,
                                            bit ng, logic [W-1:0] d);
    logic [W-1:0] base;
    if (!ld) return acc;
    base = clr ? '0 : acc;
    return ng ? base - d : base + d;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one tick: drive at falling edge, sample at the next falling edge
  task automatic tick(bit clr, bit ld, bit ng, bit o, logic [W-1:0] d, string tag);
    logic [W-1:0] exp_bus;
    ctl_clear = clr; ctl_load = ld; ctl_neg = ng; ctl_out = o; bus_in = d;
    exp_bus = o ? model : '0;
    model = ref_next(model, clr, ld, ng, d);
    @(posedge clk);
    @(negedge clk);
    check(o ? tag : "R7 idle", bus_out, exp_bus);
    check("R7 attr", {{(W-A){1'b0}}, attr_out}, '0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x;
    logic [W-1:0] r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; ctl_clear = 0; ctl_load = 0; ctl_neg = 0; ctl_out = 0; bus_in = '0;
    model = '0;
    repeat (3) @(negedge clk);
    check("R1 reset bus", bus_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", bus_out, '0);

    // R1: out before any load shows zero
    tick(0, 0, 0, 1, 16'h1234, "R1 out empty");
    tick(0, 0, 0, 0, 16'h0, "R1");

    // R2 clear-and-load discards sum
    tick(1, 1, 0, 0, 16'h0042, "R2");
    tick(0, 1, 0, 0, 16'h0010, "R3");
    tick(1, 1, 0, 0, 16'h0007, "R2");
    tick(0, 0, 0, 1, 16'h0, "R2 result");
    tick(0, 0, 0, 0, 16'h0, "R2");

    // R3 adds
    tick(0, 1, 0, 0, 16'h0100, "R3");
    tick(0, 0, 0, 1, 16'h0, "R3 result");
    tick(0, 0, 0, 0, 16'h0, "R3");

    // R4 negation
    tick(1, 1, 1, 0, 16'h0005, "R4");
    tick(0, 0, 0, 1, 16'h0, "R4 neg load");
    tick(0, 1, 1, 0, 16'h0003, "R4");
    tick(0, 0, 0, 1, 16'h0, "R4 subtract");
    tick(0, 0, 0, 0, 16'h0, "R4");

    // R5 wrap
    tick(1, 1, 0, 0, 16'hFFFF, "R5");
    tick(0, 1, 0, 0, 16'h0001, "R5");
    tick(0, 0, 0, 1, 16'h0, "R5 wrap");
    tick(0, 0, 0, 0, 16'h0, "R5");

    // R8 load low ignores clear, neg and bus; observed through out
    tick(1, 0, 1, 0, 16'hBEEF, "R8");
    tick(1, 0, 0, 0, 16'h5555, "R8");
    tick(0, 0, 0, 1, 16'h0, "R8 unchanged");
    tick(0, 0, 0, 0, 16'h0, "R8");

    // R6 out with simultaneous load shows the older value, only for one tick
    tick(1, 1, 0, 0, 16'h0020, "R6");
    tick(0, 1, 0, 1, 16'h0003, "R6 pre-load value");
    tick(0, 0, 0, 0, 16'h0, "R6 one tick only");
    tick(0, 0, 0, 1, 16'h0, "R6 after load");
    tick(0, 0, 0, 1, 16'h0, "R6 back to back");
    tick(0, 0, 0, 0, 16'h0, "R6");

    // R9 counter program
    x = '0;
    for (int c = 0; c < 4; c++) begin
      for (int pc = 0; pc < 8; pc++) begin
        r = W'($urandom);
        case (pc)
          1: tick(1, 1, 0, 0, x, "R9");
          3: tick(0, 1, 0, 0, 16'h0001, "R9");
          5: tick(0, 0, 0, 1, r, "R9 counter");
          default: tick(0, 0, $urandom_range(0, 1) == 1, 0, r, "R9");
        endcase
        if (pc == 5) begin
          check("R9 sequence", bus_out, W'(c + 1));
          x = bus_out;
        end
      end
    end

    // random mix covering R2..R8
    for (int i = 0; i < 400; i++) begin
      tick($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           W'($urandom), "R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule